// File: doc/BRIEF.md
# Doorbell Mailbox Register Controller

This block is the register front end of a host-to-device command mailbox. A host places an opcode and an input length in a 64-bit command register, fills a payload buffer, then sets a doorbell bit in a 32-bit control register. The block checks the opcode against a table of supported commands and their expected input lengths, fixed at build time through parameters. A command that passes both checks is offered to an external command handler over a valid/ready request port. The handler may read and rewrite the payload buffer through a word port and returns a result over a valid/ready response port. The block then writes the return code into the status register, rewrites the command register so that it holds only the output length, and clears the doorbell. The cleared doorbell is the host's completion signal.

The register bus is a plain strobe interface. A read returns data one cycle after the read strobe, with `bus_rvalid` marking it. On the request port the block holds `cmd_valid` and its fields steady until `cmd_ready` is seen at a clock edge. On the response port the block raises `rsp_ready` only while it is waiting for a result, and a response is taken at the first edge where both `rsp_valid` and `rsp_ready` are high. There is no back-pressure on the register bus.

Top module: `mbx_ctrl`

## Requirements
- R1: Only 4-byte and 8-byte accesses are recognised, and each must be aligned to its own size. A misaligned write changes nothing. A misaligned read returns zero.
- R2: The 32-bit capability word at byte offset 0x00 reads 11 in bits [4:0], meaning a 2048-byte payload, and zero in all other bits. Host writes to it have no effect.
- R3: The 64-bit status register at 0x10 holds the last return code in bits [47:32]. All its other bits read zero, including bit 0, the background-busy flag. The 64-bit background status word at 0x18 always reads zero. Host writes to 0x10 and 0x18 are discarded.
- R4: The command register at 0x08 takes only 8-byte writes. Its fields are opcode low byte in [7:0], opcode high byte (command set) in [15:8] and input length in [35:16]. Bits [63:36] read zero. While the doorbell is set, host writes to the command register and to the payload buffer are ignored.
- R5: The control word at 0x04 takes only 4-byte writes. Bit 0 is the doorbell, and bits 1 and 2 are enable bits that read back as written. A host write of 1 to bit 0 sets the doorbell and starts processing. A host write of 0 to bit 0 never clears the doorbell; only completion does.
- R6: An opcode ({command set, command}) absent from the supported table completes with return code 0x3 and output length 0, and no request is issued on the handler port.
- R7: A supported opcode whose input length differs from the table entry completes with return code 0x16 and output length 0, and no request is issued.
- R8: A valid command is offered once on the handler port. `cmd_opcode` and `cmd_in_len` are taken from the command register and stay stable while `cmd_valid` is high and `cmd_ready` is low.
- R9: On completion, bits [15:0] of the command register become zero and bits [35:16] hold the output length. The status code field receives the return code, and the doorbell clears at the same clock edge.
- R10: A handler output length above 2048 is reduced to 2048, and the command completes with return code 0x4 in place of the handler's code. A length of exactly 2048 passes unchanged.
- R11: The payload buffer starts at byte offset 0x20 and holds 8-byte words. The host may write a whole word or either 4-byte half. Handler writes, made through the word port while a command is in progress, are visible to the host after completion.
- R12: `bus_rvalid` is high exactly in the cycle after a read strobe, and `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 64 | Write data, aligned to bit 0 |
| bus_rdata | output | 64 | Read data, aligned to bit 0 |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| cmd_valid | output | 1 | Command offered to the handler |
| cmd_ready | input | 1 | Handler accepts the command |
| cmd_opcode | output | 16 | {command set, command} |
| cmd_in_len | output | 20 | Input payload length in bytes |
| rsp_valid | input | 1 | Handler result available |
| rsp_ready | output | 1 | Block is waiting for a result |
| rsp_code | input | 16 | Handler return code |
| rsp_out_len | input | 20 | Handler output length in bytes |
| hp_addr | input | PL_IDX_W | Payload word index for the handler |
| hp_we | input | 1 | Handler payload write enable |
| hp_wdata | input | 64 | Handler payload write data |
| hp_rdata | output | 64 | Payload word at hp_addr |

## Verification
A sequencer stuck outside idle shows at once: the doorbell stays set, so each poll of the control word reads bit 0 high and `rsp_ready` or `cmd_valid` stays raised. A wrong table lookup shows within one command. The status code reads 0x3 or 0x16 where a dispatch was expected, or the bench counts a handler request for an opcode that should have been refused. A write gate that fails to close while the doorbell is set leaves a changed command or payload value, which the read-back after completion exposes. A wrong clamp or wrong length path shows in the command register's length field on the first read after the doorbell clears.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} mbx_state_e;

  typedef struct packed {
    logic ctrl;
    logic cmd;
    logic pl_lo;
    logic pl_hi;
  } mbx_wsel_t;

  localparam logic [15:0] RC_OK       = 16'h0000;
  localparam logic [15:0] RC_UNSUP    = 16'h0003;
  localparam logic [15:0] RC_INTERNAL = 16'h0004;
  localparam logic [15:0] RC_BADLEN   = 16'h0016;

  localparam int OFS_CAP     = 0;
  localparam int OFS_CTRL    = 4;
  localparam int OFS_CMD     = 8;
  localparam int OFS_STS     = 16;
  localparam int OFS_BGSTS   = 24;
  localparam int OFS_PAYLOAD = 32;

  localparam int LEN_W = 20;
endpackage

// File: rtl/mbx_access.sv
module mbx_access
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PL_WORDS = 256,
  parameter int PL_IDX_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_size8,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       cap_val,
  input  logic [31:0]       ctrl_val,
  input  logic [63:0]       cmd_val,
  input  logic [63:0]       sts_val,
  input  logic [63:0]       pl_word,
  output mbx_wsel_t         wsel,
  output logic [PL_IDX_W-1:0] pl_idx,
  output logic [63:0]       rd_value
);
  localparam int PL_END = OFS_PAYLOAD + PL_WORDS * 8;

  logic [31:0] a32;
  logic        aligned;
  logic        in_pl;
  logic [31:0] base;
  logic [63:0] word;

  always_comb begin
    a32     = 32'(bus_addr);
    aligned = bus_size8 ? (a32[2:0] == 3'b000) : (a32[1:0] == 2'b00);
    in_pl   = (a32 >= 32'(OFS_PAYLOAD)) && (a32 < 32'(PL_END));
    base    = {a32[31:3], 3'b000};
    pl_idx  = PL_IDX_W'((a32 - 32'(OFS_PAYLOAD)) >> 3);
  end

  // write decode: each register only at its native width
  always_comb begin
    wsel       = '0;
    wsel.ctrl  = bus_wr && aligned && !bus_size8 && (a32 == 32'(OFS_CTRL));
    wsel.cmd   = bus_wr && aligned &&  bus_size8 && (a32 == 32'(OFS_CMD));
    wsel.pl_lo = bus_wr && aligned && in_pl && (bus_size8 || !a32[2]);
    wsel.pl_hi = bus_wr && aligned && in_pl && (bus_size8 ||  a32[2]);
  end

  // read mux over 8-byte lanes
  always_comb begin
    if (in_pl)                             word = pl_word;
    else if (base == 32'(OFS_CAP))         word = {ctrl_val, cap_val};
    else if (base == 32'(OFS_CMD))         word = cmd_val;
    else if (base == 32'(OFS_STS))         word = sts_val;
    else                                   word = 64'd0;
    if (!aligned)       rd_value = 64'd0;
    else if (bus_size8) rd_value = word;
    else if (a32[2])    rd_value = {32'd0, word[63:32]};
    else                rd_value = {32'd0, word[31:0]};
  end
endmodule

// File: rtl/mbx_opcheck.sv
module mbx_opcheck #(
  parameter int N_OPS = 3,
  parameter logic [N_OPS-1:0][15:0] OP_LIST  = {16'h4200, 16'h0100, 16'h0001},
  parameter logic [N_OPS-1:0][19:0] OP_INLEN = {20'd16, 20'd8, 20'd0}
) (
  input  logic [15:0] opcode,
  input  logic [19:0] in_len,
  output logic        hit,
  output logic        len_ok
);
  logic [N_OPS-1:0] match;
  logic [N_OPS-1:0] len_eq;

  for (genvar g = 0; g < N_OPS; g++) begin : g_entry
    assign match[g]  = (opcode == OP_LIST[g]);
    assign len_eq[g] = (in_len == OP_INLEN[g]);
  end

  assign hit    = |match;
  assign len_ok = |(match & len_eq);
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int PL_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             db,
  input  logic             hit,
  input  logic             len_ok,
  input  logic             cmd_ready,
  input  logic             rsp_valid,
  input  logic [15:0]      rsp_code,
  input  logic [LEN_W-1:0] rsp_len,
  output logic             cmd_valid,
  output logic             rsp_ready,
  output logic             busy,
  output logic             done,
  output logic [15:0]      done_code,
  output logic [LEN_W-1:0] done_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(PL_BYTES);

  mbx_state_e st_q, st_d;

  always_comb begin
    st_d      = st_q;
    done      = 1'b0;
    done_code = RC_OK;
    done_len  = '0;
    cmd_valid = 1'b0;
    rsp_ready = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (db) begin
          if (!hit) begin
            done      = 1'b1;
            done_code = RC_UNSUP;
          end else if (!len_ok) begin
            done      = 1'b1;
            done_code = RC_BADLEN;
          end else begin
            st_d = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        cmd_valid = 1'b1;
        if (cmd_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        rsp_ready = 1'b1;
        if (rsp_valid) begin
          done = 1'b1;
          st_d = ST_IDLE;
          if (rsp_len > LEN_MAX) begin
            done_code = RC_INTERNAL;
            done_len  = LEN_MAX;
          end else begin
            done_code = rsp_code;
            done_len  = rsp_len;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PL_BYTES = 2048,
  parameter int N_OPS    = 3,
  parameter logic [N_OPS-1:0][15:0] OP_LIST  = {16'h4200, 16'h0100, 16'h0001},
  parameter logic [N_OPS-1:0][19:0] OP_INLEN = {20'd16, 20'd8, 20'd0},
  localparam int PL_WORDS = PL_BYTES / 8,
  localparam int PL_IDX_W = $clog2(PL_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_size8,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [63:0]         bus_wdata,
  output logic [63:0]         bus_rdata,
  output logic                bus_rvalid,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [15:0]         cmd_opcode,
  output logic [19:0]         cmd_in_len,
  input  logic                rsp_valid,
  output logic                rsp_ready,
  input  logic [15:0]         rsp_code,
  input  logic [19:0]         rsp_out_len,
  input  logic [PL_IDX_W-1:0] hp_addr,
  input  logic                hp_we,
  input  logic [63:0]         hp_wdata,
  output logic [63:0]         hp_rdata
);
  localparam int PL_SHIFT = $clog2(PL_BYTES);

  logic        db_q, ien_q, bgien_q;
  logic [35:0] cmd_q;
  logic [15:0] sts_code_q;
  logic [63:0] pl_mem [PL_WORDS];

  mbx_wsel_t             wsel;
  logic [PL_IDX_W-1:0]   pl_idx;
  logic [63:0]           rd_value;
  logic                  hit, len_ok, busy, done;
  logic [15:0]           done_code;
  logic [LEN_W-1:0]      done_len;

  logic [31:0] cap_val, ctrl_val;
  logic [63:0] cmd_val, sts_val;

  assign cap_val  = 32'(PL_SHIFT);
  assign ctrl_val = {29'd0, bgien_q, ien_q, db_q};
  assign cmd_val  = {28'd0, cmd_q};
  assign sts_val  = {16'd0, sts_code_q, 32'd0};

  assign cmd_opcode = cmd_q[15:0];
  assign cmd_in_len = cmd_q[35:16];

  mbx_access #(
    .ADDR_W(ADDR_W), .PL_WORDS(PL_WORDS), .PL_IDX_W(PL_IDX_W)
  ) u_access (
    .bus_wr(bus_wr), .bus_size8(bus_size8), .bus_addr(bus_addr),
    .cap_val(cap_val), .ctrl_val(ctrl_val), .cmd_val(cmd_val),
    .sts_val(sts_val), .pl_word(pl_mem[pl_idx]),
    .wsel(wsel), .pl_idx(pl_idx), .rd_value(rd_value)
  );

  mbx_opcheck #(
    .N_OPS(N_OPS), .OP_LIST(OP_LIST), .OP_INLEN(OP_INLEN)
  ) u_opcheck (
    .opcode(cmd_q[15:0]), .in_len(cmd_q[35:16]), .hit(hit), .len_ok(len_ok)
  );

  mbx_seq #(.PL_BYTES(PL_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .db(db_q), .hit(hit), .len_ok(len_ok),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_len(rsp_out_len), .cmd_valid(cmd_valid), .rsp_ready(rsp_ready),
    .busy(busy), .done(done), .done_code(done_code), .done_len(done_len)
  );

  // control, command and status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db_q       <= 1'b0;
      ien_q      <= 1'b0;
      bgien_q    <= 1'b0;
      cmd_q      <= '0;
      sts_code_q <= '0;
    end else begin
      if (wsel.ctrl) begin
        ien_q   <= bus_wdata[1];
        bgien_q <= bus_wdata[2];
        if (bus_wdata[0]) db_q <= 1'b1;
      end
      if (done) begin
        db_q       <= 1'b0;
        sts_code_q <= done_code;
        cmd_q      <= {done_len, 16'd0};
      end else if (wsel.cmd && !db_q) begin
        cmd_q <= bus_wdata[35:0];
      end
    end
  end

  // payload buffer: host owns it while idle, handler while busy
  always_ff @(posedge clk) begin
    if (!db_q) begin
      if (wsel.pl_lo) pl_mem[pl_idx][31:0]  <= bus_size8 ? bus_wdata[31:0]  : bus_wdata[31:0];
      if (wsel.pl_hi) pl_mem[pl_idx][63:32] <= bus_size8 ? bus_wdata[63:32] : bus_wdata[31:0];
    end else if (busy && hp_we) begin
      pl_mem[hp_addr] <= hp_wdata;
    end
  end

  assign hp_rdata = pl_mem[hp_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_value;
    end
  end
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_size8,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [63:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [15:0]       cmd_opcode,
  input logic [19:0]       cmd_in_len,
  input logic              rsp_ready,
  input logic              db_q,
  input logic              done,
  input logic [35:0]       cmd_q
);
  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R12

  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_size8 ? (bus_addr[2:0] != 3'b000) : (bus_addr[1:0] != 2'b00)))
    |=> (bus_rdata == 64'd0)); // R1

  AST_ISSUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready)
    |=> (cmd_valid && $stable(cmd_opcode) && $stable(cmd_in_len))); // R8

  AST_HANDLER_NEEDS_DB: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || rsp_ready) |-> db_q); // R5

  AST_DB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (db_q && !done) |=> db_q); // R5

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!db_q && (cmd_q[15:0] == 16'd0))); // R9
endmodule

bind mbx_ctrl mbx_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_size8(bus_size8),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
  .cmd_in_len(cmd_in_len), .rsp_ready(rsp_ready), .db_q(db_q),
  .done(done), .cmd_q(cmd_q)
);

// File: tb/tb_mbx_ctrl.sv
module tb_mbx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_size8 = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic        cmd_valid, rsp_ready;
  logic        cmd_ready = 1'b0, rsp_valid = 1'b0;
  logic [15:0] cmd_opcode;
  logic [19:0] cmd_in_len;
  logic [15:0] rsp_code = '0;
  logic [19:0] rsp_out_len = '0;
  logic [7:0]  hp_addr = '0;
  logic        hp_we = 1'b0;
  logic [63:0] hp_wdata = '0;
  logic [63:0] hp_rdata;

  int nchk = 0, nfail = 0, ndisp = 0;
  logic [15:0] h_code = 0;
  logic [19:0] h_len = 0;
  int          h_delay = 1;
  logic [63:0] h_pat = 64'h0;
  logic [15:0] seen_op;
  logic [19:0] seen_len;

  always #4 clk = ~clk;

  mbx_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_size8(bus_size8), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode), .cmd_in_len(cmd_in_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_out_len(rsp_out_len), .hp_addr(hp_addr), .hp_we(hp_we),
    .hp_wdata(hp_wdata), .hp_rdata(hp_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic s8, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_size8 = s8; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic s8, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_size8 = s8;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R12 rvalid", {63'd0, bus_rvalid}, 64'd1);
    d = bus_rdata;
  endtask

  task automatic wait_done();
    logic [63:0] v;
    for (int i = 0; i < 400; i++) begin
      bus_read(12'h004, 1'b0, v);
      if (v[0] == 1'b0) return;
    end
    check("R5 doorbell never cleared", 64'd1, 64'd0);
  endtask

  task automatic ring(input logic [15:0] op, input logic [19:0] len);
    bus_write(12'h008, 1'b1, {28'd0, len, op});
    bus_write(12'h004, 1'b0, 64'd1);
  endtask

  // expected outcome from the requirements
  function automatic void predict(input logic [15:0] op, input logic [19:0] len,
                                  input logic [15:0] hc, input logic [19:0] hl,
                                  output logic [15:0] ec, output logic [19:0] el,
                                  output bit disp);
    logic [15:0] tab_op [3] = '{16'h0001, 16'h0100, 16'h4200};
    logic [19:0] tab_ln [3] = '{20'd0, 20'd8, 20'd16};
    bit found = 0;
    bit lenok = 0;
    for (int i = 0; i < 3; i++)
      if (tab_op[i] == op) begin found = 1; lenok = (tab_ln[i] == len); end
    disp = 0; el = 0;
    if (!found) ec = 16'h0003;
    else if (!lenok) ec = 16'h0016;
    else begin
      disp = 1;
      if (hl > 20'd2048) begin ec = 16'h0004; el = 20'd2048; end
      else begin ec = hc; el = hl; end
    end
  endfunction

  task automatic run_and_check(input string tag, input logic [15:0] op, input logic [19:0] len);
    logic [15:0] ec; logic [19:0] el; bit disp; int d0;
    logic [63:0] v;
    predict(op, len, h_code, h_len, ec, el, disp);
    d0 = ndisp;
    ring(op, len);
    wait_done();
    bus_read(12'h010, 1'b1, v);
    check({tag, " status"}, v, {16'd0, ec, 32'd0});
    bus_read(12'h008, 1'b1, v);
    check({tag, " R9 cmd reg"}, v, {28'd0, el, 16'd0});
    check({tag, " dispatch count"}, 64'(ndisp - d0), 64'(disp));
    if (disp) check({tag, " R8 opcode seen"}, {28'd0, seen_len, seen_op}, {28'd0, len, op});
  endtask

  // handler model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        ndisp++;
        seen_op = cmd_opcode; seen_len = cmd_in_len;
        repeat (h_delay) @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        hp_addr = 8'd0; hp_wdata = h_pat; hp_we = 1'b1;
        @(negedge clk);
        hp_we = 1'b0;
        rsp_code = h_code; rsp_out_len = h_len; rsp_valid = 1'b1;
        while (!rsp_ready) @(negedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] v, w;
    logic [15:0] tab_op [3] = '{16'h0001, 16'h0100, 16'h4200};
    logic [19:0] tab_ln [3] = '{20'd0, 20'd8, 20'd16};
    void'($urandom(32'h5a17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset rvalid", {63'd0, bus_rvalid}, 64'd0);
    check("R8 reset cmd_valid", {62'd0, cmd_valid, rsp_ready}, 64'd0);

    // R2 capability
    bus_read(12'h000, 1'b0, v);
    check("R2 cap", v, 64'd11);
    bus_write(12'h000, 1'b0, 64'hFFFF_FFFF);
    bus_read(12'h000, 1'b0, v);
    check("R2 cap after write", v, 64'd11);

    // R1 alignment
    bus_write(12'h020, 1'b1, 64'h1122_3344_5566_7788);
    bus_write(12'h024, 1'b1, 64'hDEAD_BEEF_DEAD_BEEF);
    bus_write(12'h022, 1'b0, 64'hCAFE);
    bus_read(12'h020, 1'b1, v);
    check("R1 misaligned write ignored", v, 64'h1122_3344_5566_7788);
    bus_read(12'h022, 1'b0, v);
    check("R1 misaligned 4B read", v, 64'd0);
    bus_read(12'h024, 1'b1, v);
    check("R1 misaligned 8B read", v, 64'd0);

    // R3 status read-only
    bus_write(12'h010, 1'b1, '1);
    bus_read(12'h010, 1'b1, v);
    check("R3 status discard", v, 64'd0);
    bus_write(12'h018, 1'b1, '1);
    bus_read(12'h018, 1'b1, v);
    check("R3 bg status", v, 64'd0);

    // R4 command register width and layout
    bus_write(12'h008, 1'b1, '1);
    bus_read(12'h008, 1'b1, v);
    check("R4 cmd mask", v, 64'h0000_000F_FFFF_FFFF);
    bus_write(12'h008, 1'b0, 64'd0);
    bus_read(12'h008, 1'b1, v);
    check("R4 4B cmd write ignored", v, 64'h0000_000F_FFFF_FFFF);

    // R5 enable bits read back, doorbell untouched
    bus_write(12'h004, 1'b0, 64'h6);
    bus_read(12'h004, 1'b0, v);
    check("R5 ctrl enables", v, 64'h6);
    bus_write(12'h004, 1'b0, 64'h0);

    // R11 half-word payload writes
    bus_write(12'h028, 1'b0, 64'hAAAA_0001);
    bus_write(12'h02C, 1'b0, 64'hBBBB_0002);
    bus_read(12'h028, 1'b1, v);
    check("R11 halves", v, 64'hBBBB_0002_AAAA_0001);
    bus_read(12'h02C, 1'b0, v);
    check("R11 upper half read", v, 64'hBBBB_0002);

    // directed commands
    h_code = 16'h0000; h_len = 20'd24; h_pat = 64'h0F0E_0D0C_0B0A_0908;
    run_and_check("R9 good", 16'h0001, 20'd0);
    bus_read(12'h020, 1'b1, v);
    check("R11 handler write visible", v, 64'h0F0E_0D0C_0B0A_0908);
    run_and_check("R6 unsupported", 16'h7F00, 20'd0);
    run_and_check("R7 bad length", 16'h0100, 20'd4);
    h_code = 16'h0002; h_len = 20'd4000;
    run_and_check("R10 clamp", 16'h4200, 20'd16);
    h_len = 20'd2048;
    run_and_check("R10 exact max", 16'h4200, 20'd16);

    // writes while the doorbell is set
    h_delay = 24; h_code = 16'h0000; h_len = 20'd8;
    ring(16'h0100, 20'd8);
    bus_write(12'h004, 1'b0, 64'h0);
    bus_read(12'h004, 1'b0, v);
    check("R5 host cannot clear doorbell", {63'd0, v[0]}, 64'd1);
    bus_write(12'h008, 1'b1, 64'h0000_0001_ABCD);
    bus_write(12'h028, 1'b1, 64'h5555_5555_5555_5555);
    wait_done();
    bus_read(12'h008, 1'b1, v);
    check("R4 cmd write blocked", v, 64'h0000_0000_0008_0000);
    bus_read(12'h028, 1'b1, v);
    check("R4 payload write blocked", v, 64'hBBBB_0002_AAAA_0001);
    h_delay = 1;

    // constrained random
    for (int it = 0; it < 40; it++) begin
      logic [15:0] op; logic [19:0] ln; int r; logic [7:0] wi;
      r = $urandom % 4;
      op = (r < 3) ? tab_op[r] : 16'($urandom);
      ln = ($urandom % 2 == 0 && r < 3) ? tab_ln[r] : 20'($urandom % 32);
      h_code = 16'($urandom % 22);
      h_len = 20'($urandom % 2600);
      h_pat = {$urandom, $urandom};
      run_and_check("R9 random", op, ln);
      wi = 8'($urandom % 256);
      w = {$urandom, $urandom};
      bus_write(12'h020 + {1'b0, wi, 3'b000}, 1'b0, {32'd0, w[31:0]});
      bus_write(12'h024 + {1'b0, wi, 3'b000}, 1'b0, {32'd0, w[63:32]});
      bus_read(12'h020 + {1'b0, wi, 3'b000}, 1'b1, v);
      check("R11 random payload", v, w);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule